// File: doc/BRIEF.md
# Source-Routed Control Frame Header Parser

This block takes a byte-wide stream of control frames and splits each frame on the fly. Every frame opens with a source-routing header whose sections have no fixed length. Bytes below 0xFE are routing entries. The value 0xFE opens an optional return section, and 0xFF closes the header. The byte after 0xFF is the message type. All bytes after the type byte are payload.

The forward and return entries go into two small indexed buffers, which can be read through their own index ports. Once the type byte has been taken, the type, the two entry counts and a header-valid level appear on sideband pins. The payload then leaves on a registered valid/ready output stream, with the end-of-frame marker preserved.

Both streams follow valid/ready rules. An input byte moves when `s_tvalid` and `s_tready` are both high at a rising edge, and an output byte moves when `m_tvalid` and `m_tready` are both high. Once `m_tvalid` is high, the output beat stays unchanged until it is taken. Back-pressure on the output reaches `s_tready` only during the payload phase. A header that breaks the rules produces a one-cycle error strobe, and the parser then swallows the remainder of that frame.

Top module: `route_hdr_parser`

## Requirements
- R1: After a synchronous active-high reset the outputs are in their idle state: `s_tready`=1, `m_tvalid`=0, `hdr_valid`=0, `err`=0 and both counts are 0.
- R2: Header bytes below 0xFE that come before any marker are stored in arrival order at forward indices 0, 1, 2, and so on. `fwd_cnt` gives how many were stored.
- R3: A 0xFE byte that follows the forward section opens the return section. The bytes below 0xFE that follow it are stored at return indices 0, 1, and so on, and `ret_cnt` gives how many.
- R4: The byte after 0xFF is the type. `hdr_valid`, `hdr_type` and the counts go valid in the cycle after the type byte is accepted. This is exactly one cycle before the first payload byte can show on `m_tvalid`, and `m_tvalid` is never high while `hdr_valid` is low.
- R5: Payload bytes come out in order, and `m_tlast` is set on the final byte. While `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold steady.
- R6: When the input is continuous and `m_tready` stays high, payload bytes move at one byte per cycle with no gaps.
- R7: A 0xFE byte inside the return section makes the header malformed. `err` pulses for one cycle, the rest of the frame is accepted and thrown away, and no header or payload is presented.
- R8: If tlast arrives on any byte before the type byte, `err` pulses for one cycle, the frame ends there and no output is produced.
- R9: Each section holds up to PATH_DEPTH entries (default 8). One more entry raises `err` and drops the rest of the frame. Exactly PATH_DEPTH entries is accepted.
- R10: `hdr_valid` stays high and unchanged until the final payload byte has moved on the output, and it drops in the cycle after that. A frame whose type byte carries tlast has no payload, and `hdr_valid` is high for exactly one cycle.
- R11: `s_tready` is high for every header byte and for dropped bytes, whatever `m_tready` is doing. It is low while a finished frame's last byte waits in the output register.
- R12: A frame that starts with 0xFF has two empty sections, so both counts are reported as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Incoming frame byte |
| s_tvalid | input | 1 | Incoming byte valid |
| s_tlast | input | 1 | Incoming byte ends the frame |
| s_tready | output | 1 | Parser accepts a byte |
| m_tdata | output | 8 | Payload byte |
| m_tvalid | output | 1 | Payload byte valid |
| m_tlast | output | 1 | Payload byte ends the frame |
| m_tready | input | 1 | Downstream accepts a payload byte |
| hdr_valid | output | 1 | Parsed header fields valid for the current frame |
| hdr_type | output | 8 | Message type byte |
| fwd_cnt | output | $clog2(PATH_DEPTH+1) | Number of forward entries |
| ret_cnt | output | $clog2(PATH_DEPTH+1) | Number of return entries |
| fwd_rd_idx | input | $clog2(PATH_DEPTH) | Forward buffer read index |
| fwd_rd_data | output | 8 | Forward entry at that index |
| ret_rd_idx | input | $clog2(PATH_DEPTH) | Return buffer read index |
| ret_rd_data | output | 8 | Return entry at that index |
| err | output | 1 | One-cycle malformed-frame strobe |

## Verification
Two events can land in the same edge: the stalled final payload byte being released, and the header fields being cleared. The bench provokes this by holding `m_tready` low after a one-byte-payload frame has been fully accepted. During that stall it reads both path buffers and checks that `s_tready` is low. It then raises `m_tready` and checks that exactly one last beat moves and that `hdr_valid` drops on the following cycle. A continuous-stream frame separately checks that the first payload beat appears one cycle after `hdr_valid`, with no gaps in between.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MARK_RET = 8'hFE;
  localparam logic [BYTE_W-1:0] MARK_END = 8'hFF;

  typedef enum logic [2:0] {
    ST_FWD,
    ST_RET,
    ST_TYP,
    ST_PAY,
    ST_DRAIN,
    ST_DROP
  } rhp_state_e;
endpackage

// File: rtl/rhp_path_store.sv
module rhp_path_store #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  logic [7:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g)) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

  // R9
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < DEPTH));
endmodule

// File: rtl/rhp_ctrl.sv
module rhp_ctrl
  import rhp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       s_tdata,
  input  logic             s_tvalid,
  input  logic             s_tlast,
  output logic             s_tready,
  output logic             pay_valid,
  input  logic             pay_ready,
  input  logic             out_busy,
  input  logic             out_done,
  output logic             fwd_we,
  output logic             ret_we,
  output logic [CNT_W-1:0] fwd_cnt,
  output logic [CNT_W-1:0] ret_cnt,
  output logic             hdr_valid,
  output logic [7:0]       hdr_type,
  output logic             err
);
  rhp_state_e state, nxt;
  logic s_fire, is_entry, fwd_full, ret_full, err_now, drain_exit;

  assign s_fire   = s_tvalid && s_tready;
  assign is_entry = s_tdata < MARK_RET;
  assign fwd_full = fwd_cnt == CNT_W'(DEPTH);
  assign ret_full = ret_cnt == CNT_W'(DEPTH);
  assign drain_exit = (state == ST_DRAIN) && (!out_busy || out_done);

  always_comb begin
    case (state)
      ST_PAY:   s_tready = pay_ready;
      ST_DRAIN: s_tready = 1'b0;
      default:  s_tready = 1'b1;
    endcase
  end

  assign pay_valid = (state == ST_PAY) && s_tvalid;
  assign fwd_we = s_fire && (state == ST_FWD) && is_entry && !fwd_full;
  assign ret_we = s_fire && (state == ST_RET) && is_entry && !ret_full;

  always_comb begin
    nxt = state;
    err_now = 1'b0;
    case (state)
      ST_FWD: if (s_fire) begin
        if (is_entry) err_now = fwd_full || s_tlast;
        else if (s_tlast) err_now = 1'b1;
        else if (s_tdata == MARK_RET) nxt = ST_RET;
        else nxt = ST_TYP;
      end
      ST_RET: if (s_fire) begin
        if (is_entry) err_now = ret_full || s_tlast;
        else if (s_tlast || s_tdata == MARK_RET) err_now = 1'b1;
        else nxt = ST_TYP;
      end
      ST_TYP:   if (s_fire) nxt = s_tlast ? ST_DRAIN : ST_PAY;
      ST_PAY:   if (s_fire && s_tlast) nxt = ST_DRAIN;
      ST_DRAIN: if (drain_exit) nxt = ST_FWD;
      ST_DROP:  if (s_fire && s_tlast) nxt = ST_FWD;
      default:  nxt = ST_FWD;
    endcase
    if (err_now) nxt = s_tlast ? ST_FWD : ST_DROP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FWD;
      err       <= 1'b0;
      fwd_cnt   <= '0;
      ret_cnt   <= '0;
      hdr_valid <= 1'b0;
      hdr_type  <= '0;
    end else begin
      state <= nxt;
      err   <= err_now;
      if (err_now || drain_exit) begin
        fwd_cnt <= '0;
        ret_cnt <= '0;
      end else begin
        if (fwd_we) fwd_cnt <= fwd_cnt + 1'b1;
        if (ret_we) ret_cnt <= ret_cnt + 1'b1;
      end
      if (state == ST_TYP && s_fire) begin
        hdr_valid <= 1'b1;
        hdr_type  <= s_tdata;
      end else if (drain_exit) begin
        hdr_valid <= 1'b0;
      end
    end
  end

  // R10
  hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> !hdr_valid ||
      ($stable(hdr_type) && $stable(fwd_cnt) && $stable(ret_cnt)));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_cnt <= CNT_W'(DEPTH)) && (ret_cnt <= CNT_W'(DEPTH)));
  // R7
  err_no_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !hdr_valid);
endmodule

// File: rtl/rhp_out_reg.sv
module rhp_out_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] m_tdata,
  output logic       m_tvalid,
  output logic       m_tlast,
  input  logic       m_tready
);
  assign in_ready = !m_tvalid || m_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
    end else if (in_ready) begin
      m_tvalid <= in_valid;
      m_tdata  <= in_data;
      m_tlast  <= in_last;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
endmodule

// File: rtl/route_hdr_parser.sv
module route_hdr_parser #(
  parameter int PATH_DEPTH = 8,
  localparam int CNT_W = $clog2(PATH_DEPTH + 1),
  localparam int IDX_W = $clog2(PATH_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       s_tdata,
  input  logic             s_tvalid,
  input  logic             s_tlast,
  output logic             s_tready,
  output logic [7:0]       m_tdata,
  output logic             m_tvalid,
  output logic             m_tlast,
  input  logic             m_tready,
  output logic             hdr_valid,
  output logic [7:0]       hdr_type,
  output logic [CNT_W-1:0] fwd_cnt,
  output logic [CNT_W-1:0] ret_cnt,
  input  logic [IDX_W-1:0] fwd_rd_idx,
  output logic [7:0]       fwd_rd_data,
  input  logic [IDX_W-1:0] ret_rd_idx,
  output logic [7:0]       ret_rd_data,
  output logic             err
);
  logic pay_valid, pay_ready, out_done, fwd_we, ret_we;

  assign out_done = m_tvalid && m_tready && m_tlast;

  rhp_ctrl #(.DEPTH(PATH_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .pay_valid(pay_valid), .pay_ready(pay_ready),
    .out_busy(m_tvalid), .out_done(out_done),
    .fwd_we(fwd_we), .ret_we(ret_we),
    .fwd_cnt(fwd_cnt), .ret_cnt(ret_cnt),
    .hdr_valid(hdr_valid), .hdr_type(hdr_type), .err(err)
  );

  rhp_path_store #(.DEPTH(PATH_DEPTH)) u_fwd (
    .clk(clk), .rst(rst), .wr_en(fwd_we), .wr_idx(fwd_cnt[IDX_W-1:0]),
    .wr_data(s_tdata), .rd_idx(fwd_rd_idx), .rd_data(fwd_rd_data)
  );

  rhp_path_store #(.DEPTH(PATH_DEPTH)) u_ret (
    .clk(clk), .rst(rst), .wr_en(ret_we), .wr_idx(ret_cnt[IDX_W-1:0]),
    .wr_data(s_tdata), .rd_idx(ret_rd_idx), .rd_data(ret_rd_data)
  );

  rhp_out_reg u_out (
    .clk(clk), .rst(rst),
    .in_data(s_tdata), .in_valid(pay_valid), .in_last(s_tlast), .in_ready(pay_ready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
  );

  // R4
  pay_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> hdr_valid);
endmodule

// File: tb/sim_route_hdr_parser.sv
`timescale 1ns/1ps
module sim_route_hdr_parser;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [7:0] m_tdata;
  logic m_tvalid, m_tlast;
  logic m_tready = 1'b1;
  logic hdr_valid, err;
  logic [7:0] hdr_type, fwd_rd_data, ret_rd_data;
  logic [CNT_W-1:0] fwd_cnt, ret_cnt;
  logic [IDX_W-1:0] fwd_rd_idx = '0, ret_rd_idx = '0;

  always #2 clk = ~clk;

  route_hdr_parser #(.PATH_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .hdr_valid(hdr_valid), .hdr_type(hdr_type), .fwd_cnt(fwd_cnt), .ret_cnt(ret_cnt),
    .fwd_rd_idx(fwd_rd_idx), .fwd_rd_data(fwd_rd_data),
    .ret_rd_idx(ret_rd_idx), .ret_rd_data(ret_rd_data), .err(err)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, nb = 0, nerr = 0, nhdr = 0, hdr_c0 = 0, waits = 0;
  int hdr_fc = 0, hdr_rc = 0, hdr_ty = 0;
  logic [7:0] beat_d [64];
  logic beat_l [64];
  int beat_c [64];
  logic [7:0] fq [$];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (m_tvalid && m_tready && nb < 64) begin
        beat_d[nb] = m_tdata; beat_l[nb] = m_tlast; beat_c[nb] = cyc; nb++;
      end
      if (err) nerr++;
      if (hdr_valid) begin
        if (nhdr == 0) begin
          hdr_c0 = cyc; hdr_fc = int'(fwd_cnt); hdr_rc = int'(ret_cnt); hdr_ty = int'(hdr_type);
        end
        nhdr++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nb = 0; nerr = 0; nhdr = 0; waits = 0;
  endtask

  task automatic send_fq();
    for (int i = 0; i < fq.size(); i++) begin
      logic acc;
      s_tdata = fq[i]; s_tlast = (i == fq.size() - 1); s_tvalid = 1'b1;
      do begin
        @(negedge clk); acc = s_tready;
        @(posedge clk); #1;
        if (!acc) waits++;
      end while (!acc);
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 s_tready", int'(s_tready), 1);
    chk("R1 m_tvalid", int'(m_tvalid), 0);
    chk("R1 hdr_valid", int'(hdr_valid), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 fwd_cnt", int'(fwd_cnt), 0);
  endtask

  task automatic t_paths();
    clear_mon();
    m_tready = 1'b0;
    fq = {8'h05, 8'h0A, 8'h11, 8'hFE, 8'h22, 8'h33, 8'hFF, 8'h12, 8'hAB};
    send_fq();
    chk("R11 no header stall", waits, 0);
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R11 drain s_tready", int'(s_tready), 0);
    chk("R4 hdr_valid", int'(hdr_valid), 1);
    chk("R4 hdr_type", int'(hdr_type), 8'h12);
    chk("R2 fwd_cnt", int'(fwd_cnt), 3);
    chk("R3 ret_cnt", int'(ret_cnt), 2);
    chk("R5 stalled valid", int'(m_tvalid), 1);
    chk("R5 stalled data", int'(m_tdata), 8'hAB);
    chk("R5 stalled last", int'(m_tlast), 1);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] ef [3] = '{8'h05, 8'h0A, 8'h11};
      @(posedge clk); #1; fwd_rd_idx = IDX_W'(i);
      @(negedge clk);
      chk("R2 fwd entry", int'(fwd_rd_data), int'(ef[i]));
    end
    for (int i = 0; i < 2; i++) begin
      logic [7:0] er [2] = '{8'h22, 8'h33};
      @(posedge clk); #1; ret_rd_idx = IDX_W'(i);
      @(negedge clk);
      chk("R3 ret entry", int'(ret_rd_data), int'(er[i]));
    end
    @(posedge clk); #1; m_tready = 1'b1;
    @(negedge clk);
    chk("R10 hdr held at release", int'(hdr_valid), 1);
    @(negedge clk);
    chk("R10 hdr drops after last", int'(hdr_valid), 0);
    settle();
    chk("R5 one beat", nb, 1);
    chk("R5 beat last", int'(beat_l[0]), 1);
    chk("R7 no err", nerr, 0);
  endtask

  task automatic t_stream();
    clear_mon();
    m_tready = 1'b1;
    fq = {8'hFF, 8'h40, 8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65};
    send_fq();
    settle();
    chk("R12 fwd empty", hdr_fc, 0);
    chk("R12 ret empty", hdr_rc, 0);
    chk("R4 type", hdr_ty, 8'h40);
    chk("R5 beat count", nb, 6);
    chk("R4 first beat after hdr", beat_c[0], hdr_c0 + 1);
    for (int i = 0; i < 6; i++) begin
      chk("R5 payload byte", int'(beat_d[i]), 8'h10 + 8'h11 * i);
      chk("R5 last flag", int'(beat_l[i]), (i == 5) ? 1 : 0);
      if (i > 0) chk("R6 no gap", beat_c[i], beat_c[i-1] + 1);
    end
    chk("R10 hdr length", nhdr, 7);
    chk("R11 stream waits", waits, 0);
  endtask

  task automatic t_hdr_only();
    clear_mon();
    fq = {8'hFF, 8'h30};
    send_fq();
    settle();
    chk("R10 header-only hdr cycles", nhdr, 1);
    chk("R10 header-only type", hdr_ty, 8'h30);
    chk("R10 header-only beats", nb, 0);
    chk("R10 header-only err", nerr, 0);
  endtask

  task automatic t_bad_marker();
    clear_mon();
    fq = {8'h01, 8'hFE, 8'h02, 8'hFE, 8'h55, 8'h66, 8'h77};
    send_fq();
    settle();
    chk("R7 err pulses", nerr, 1);
    chk("R7 no beats", nb, 0);
    chk("R7 no hdr", nhdr, 0);
    chk("R11 drop waits", waits, 0);
  endtask

  task automatic t_early_last();
    clear_mon();
    fq = {8'h01, 8'hFF};
    send_fq();
    fq = {8'h07};
    send_fq();
    fq = {8'h03, 8'hFE};
    send_fq();
    settle();
    chk("R8 err pulses", nerr, 3);
    chk("R8 no beats", nb, 0);
    chk("R8 no hdr", nhdr, 0);
  endtask

  task automatic t_overflow();
    clear_mon();
    fq = {};
    for (int i = 1; i <= DEPTH + 1; i++) fq.push_back(8'(i));
    fq.push_back(8'hFF); fq.push_back(8'h12); fq.push_back(8'hAA);
    send_fq();
    settle();
    chk("R9 overflow err", nerr, 1);
    chk("R9 overflow no beats", nb, 0);
    chk("R9 overflow no hdr", nhdr, 0);
    clear_mon();
    fq = {};
    for (int i = 1; i <= DEPTH; i++) fq.push_back(8'(i));
    fq.push_back(8'hFF); fq.push_back(8'h12); fq.push_back(8'hAA);
    send_fq();
    settle();
    chk("R9 full fwd count", hdr_fc, DEPTH);
    chk("R9 full no err", nerr, 0);
    chk("R9 full beat", nb, 1);
    chk("R9 full beat data", int'(beat_d[0]), 8'hAA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    @(posedge clk); #1;
    t_paths();
    t_stream();
    t_hdr_only();
    t_bad_marker();
    t_stream();
    t_early_last();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule